// File: doc/BRIEF.md
# DMA Read Channel Control Registers

This block is the register front end of one DMA read channel. A host-side agent reaches it over a small request/acknowledge register bus carrying a read/write select, a register index, write data and returned read data. The block holds the channel's configuration words: an operating mode, a 64-bit host address split into low and high halves, and a local address. It exposes them as plain outputs to a transfer engine, which is not part of this block.

A control register turns the channel on and off and can flush the engine's FIFO. These writes become single-cycle start and FIFO-flush pulses plus a run level. A read-only status word reports whether the engine has accepted the run command, and a sticky completion flag that the engine sets through a done input. Software programs the addresses, starts the channel and polls the completion flag.

Top module: `dma_chan_ctrl`

## Requirements
- R1: A request is taken in a cycle where `busReq` is 1 and `busAck` is 0. `busAck` is then 1 for exactly the following cycle.
- R2: `busRdata` carries the addressed register while `busAck` is 1 after a read (`busWr` = 0), and is zero in every other cycle.
- R3: Indices 8 (mode), 20 (host address low), 21 (host address high) and 23 (local address) are 32-bit read/write registers. They drive `modeCfg`, `hostAddr` = {index 21, index 20} and `localAddr`.
- R4: Index 9 is the control register, and its bit 0 is the run level on `engRun`. A write with bit 0 = 1 while the channel is stopped gives a one-cycle `engStart` in the acknowledge cycle. Rewriting bit 0 = 1 while running gives no pulse. Writing bit 0 = 0 stops the channel.
- R5: A write to index 9 with bit 4 = 1 gives a one-cycle `engFifoRst` in the acknowledge cycle. Bit 4 then clears by itself, so a later read of index 9 returns bit 4 = 0 and bit 0 = run.
- R6: Index 16 is the read-only status word. Bit 8 = run AND `engReady`, bit 5 = completion flag, and all other bits are 0. Writes to index 16 change nothing.
- R7: The completion flag is set by `engDone` = 1 while running. It stays set until the next start pulse or FIFO flush. `engDone` while stopped is ignored.
- R8: When a FIFO flush is written in the same cycle that `engDone` is seen, the flush wins and the completion flag reads 0.
- R9: Reads of any other index return 0, and writes to them change no register.
- R10: `initDone` is 0 during reset and 1 from the first clock edge after reset is released.
- R11: During reset, all registers, pulses, `busAck` and `busRdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReq | input | 1 | Register access request |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Register index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busAck |
| busAck | output | 1 | One-cycle acknowledge |
| initDone | output | 1 | Block out of reset and ready |
| engReady | input | 1 | Engine has accepted the run command |
| engDone | input | 1 | Engine reports the transfer finished |
| engRun | output | 1 | Channel run level |
| engStart | output | 1 | One-cycle start pulse |
| engFifoRst | output | 1 | One-cycle FIFO flush pulse |
| modeCfg | output | 32 | Mode register value |
| hostAddr | output | 64 | Host address {high, low} |
| localAddr | output | 32 | Local address register value |

## Verification
The done report from the engine and a control write can land on the same clock edge, and both act on the completion flag. The bench provokes this by raising `engDone` in the same cycle that it issues a control write with the flush bit set while the channel runs. It then reads status and expects bit 5 clear with bit 8 still set. Start and flush clearing are also checked separately against a flag set earlier, and every register index is swept with write-then-read patterns computed in the bench.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int IDX_MODE  = 8;
  localparam int IDX_CTRL  = 9;
  localparam int IDX_STAT  = 16;
  localparam int IDX_HLO   = 20;
  localparam int IDX_HHI   = 21;
  localparam int IDX_LOC   = 23;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_FRST_BIT = 4;
  localparam int STAT_DONE_BIT = 5;
  localparam int STAT_RDY_BIT  = 8;

  // plain read/write words: 0 mode, 1 host low, 2 host high, 3 local
  localparam int NPLAIN = 4;

  function automatic int plainIdx(input int k);
    case (k)
      0:       plainIdx = IDX_MODE;
      1:       plainIdx = IDX_HLO;
      2:       plainIdx = IDX_HHI;
      default: plainIdx = IDX_LOC;
    endcase
  endfunction

  typedef struct packed {
    logic              take;
    logic              wrEn;
    logic [NPLAIN-1:0] plainHit;
    logic              ctrlHit;
    logic              statHit;
  } busStrobe_t;
endpackage

// File: rtl/dma_chan_busctl.sv
module dma_chan_busctl
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              busAck,
  output logic              initDone,
  output busStrobe_t        strobe
);
  logic ackQ;
  logic initQ;
  logic [NPLAIN-1:0] plainHit;

  for (genvar k = 0; k < NPLAIN; k++) begin : gHit
    assign plainHit[k] = (busAddr == ADDR_W'(plainIdx(k)));
  end

  always_comb begin
    strobe.take     = busReq && !ackQ;
    strobe.wrEn     = busWr;
    strobe.plainHit = plainHit;
    strobe.ctrlHit  = (busAddr == ADDR_W'(IDX_CTRL));
    strobe.statHit  = (busAddr == ADDR_W'(IDX_STAT));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackQ  <= 1'b0;
      initQ <= 1'b0;
    end else begin
      ackQ  <= busReq && !ackQ;
      initQ <= 1'b1;
    end
  end

  assign busAck   = ackQ;
  assign initDone = initQ;

  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> busAck); // R1
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck); // R1
  AST_INIT_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone); // R10
endmodule

// File: rtl/dma_chan_regbank.sv
module dma_chan_regbank
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  busStrobe_t               strobe,
  input  logic [DATA_W-1:0]        busWdata,
  input  logic                     engReady,
  input  logic                     engDone,
  output logic [DATA_W-1:0]        busRdata,
  output logic                     engRun,
  output logic                     engStart,
  output logic                     engFifoRst,
  output logic [NPLAIN*DATA_W-1:0] plainOut
);
  logic wrAcc, rdAcc;
  logic runQ, startQ, frstQ, doneQ;
  logic startNow, frstNow;
  logic [DATA_W-1:0] plainQ [NPLAIN];
  logic [DATA_W-1:0] plainRd [NPLAIN+1];
  logic [DATA_W-1:0] ctrlWord, statWord, rdMux;

  assign wrAcc = strobe.take && strobe.wrEn;
  assign rdAcc = strobe.take && !strobe.wrEn;

  assign startNow = wrAcc && strobe.ctrlHit && busWdata[CTRL_RUN_BIT] && !runQ;
  assign frstNow  = wrAcc && strobe.ctrlHit && busWdata[CTRL_FRST_BIT];

  assign plainRd[0] = '0;
  for (genvar k = 0; k < NPLAIN; k++) begin : gPlain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) plainQ[k] <= '0;
      else if (wrAcc && strobe.plainHit[k]) plainQ[k] <= busWdata;
    end
    assign plainRd[k+1] = plainRd[k] | (strobe.plainHit[k] ? plainQ[k] : '0);
    assign plainOut[k*DATA_W +: DATA_W] = plainQ[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      startQ <= 1'b0;
      frstQ  <= 1'b0;
    end else begin
      startQ <= startNow;
      frstQ  <= frstNow;
      if (wrAcc && strobe.ctrlHit) runQ <= busWdata[CTRL_RUN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    doneQ <= 1'b0;
    else if (startNow || frstNow) doneQ <= 1'b0;
    else if (engDone && runQ)     doneQ <= 1'b1;
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[CTRL_RUN_BIT]  = runQ;
    ctrlWord[CTRL_FRST_BIT] = frstQ;
    statWord = '0;
    statWord[STAT_RDY_BIT]  = runQ && engReady;
    statWord[STAT_DONE_BIT] = doneQ;
    rdMux = plainRd[NPLAIN]
          | (strobe.ctrlHit ? ctrlWord : '0)
          | (strobe.statHit ? statWord : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      busRdata <= '0;
    else if (rdAcc) busRdata <= rdMux;
    else            busRdata <= '0;
  end

  assign engRun     = runQ;
  assign engStart   = startQ;
  assign engFifoRst = frstQ;

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdAcc |=> (busRdata == '0)); // R2
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart); // R4
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> engRun); // R4
  AST_FIFO_SELFCLR: assert property (@(posedge clk) disable iff (!rstN)
    engFifoRst |=> !engFifoRst); // R5
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> $past(engDone && engRun)); // R7
  AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rstN)
    engFifoRst |-> !doneQ); // R8
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busReq,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic                busAck,
  output logic                initDone,
  input  logic                engReady,
  input  logic                engDone,
  output logic                engRun,
  output logic                engStart,
  output logic                engFifoRst,
  output logic [DATA_W-1:0]   modeCfg,
  output logic [2*DATA_W-1:0] hostAddr,
  output logic [DATA_W-1:0]   localAddr
);
  busStrobe_t strobe;
  logic [NPLAIN*DATA_W-1:0] plainOut;

  dma_chan_busctl #(.ADDR_W(ADDR_W)) uBus (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWr(busWr),
    .busAddr(busAddr), .busAck(busAck), .initDone(initDone), .strobe(strobe)
  );

  dma_chan_regbank #(.DATA_W(DATA_W)) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .engReady(engReady), .engDone(engDone), .busRdata(busRdata),
    .engRun(engRun), .engStart(engStart), .engFifoRst(engFifoRst),
    .plainOut(plainOut)
  );

  assign modeCfg   = plainOut[0*DATA_W +: DATA_W];
  assign hostAddr  = {plainOut[2*DATA_W +: DATA_W], plainOut[1*DATA_W +: DATA_W]};
  assign localAddr = plainOut[3*DATA_W +: DATA_W];
endmodule

// File: tb/sim_dma_chan_ctrl.sv
module sim_dma_chan_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic busReq = 0, busWr = 0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic busAck, initDone, engReady = 0, engDone = 0;
  logic engRun, engStart, engFifoRst;
  logic [31:0] modeCfg, localAddr;
  logic [63:0] hostAddr;

  int nChk = 0, nBad = 0;
  logic ackSeen, startSeen, frstSeen;
  logic [31:0] rdv;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctrl u0 (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck), .initDone(initDone),
    .engReady(engReady), .engDone(engDone), .engRun(engRun), .engStart(engStart),
    .engFifoRst(engFifoRst), .modeCfg(modeCfg), .hostAddr(hostAddr), .localAddr(localAddr)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int idx);
    pat = 32'hC300_0000 | (32'(idx) << 16) | (~32'(idx) & 32'h0000_FFFF);
  endfunction

  // one access; withDone raises engDone in the request cycle
  task automatic xfer(input logic wr, input int idx, input logic [31:0] d,
                      input logic withDone = 1'b0);
    @(negedge clk);
    busReq = 1; busWr = wr; busAddr = 5'(idx); busWdata = d; engDone = withDone;
    @(negedge clk);
    ackSeen = busAck; rdv = busRdata; startSeen = engStart; frstSeen = engFifoRst;
    busReq = 0; engDone = 0;
  endtask

  task automatic pulseDone();
    @(negedge clk); engDone = 1;
    @(negedge clk); engDone = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChk++; nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic found;
    repeat (3) @(negedge clk);
    chk("R11 reset ack/rdata", {busAck, busRdata}, '0);
    chk("R11 reset pulses/run", {engRun, engStart, engFifoRst}, '0);
    chk("R11 reset regs", {modeCfg, localAddr}, '0);
    chk("R10 initDone in reset", initDone, 0);
    rstN = 1;
    @(negedge clk);
    chk("R10 initDone after reset", initDone, 1);

    // R1/R2 handshake timing
    xfer(1'b0, 8, '0);
    chk("R1 ack after request", ackSeen, 1);
    @(negedge clk);
    chk("R1 ack single cycle", busAck, 0);
    chk("R2 rdata idle zero", busRdata, 0);

    // sweep: write every index except control, then read all back
    for (int i = 0; i < 32; i++) if (i != 9) xfer(1'b1, i, pat(i));
    for (int i = 0; i < 32; i++) begin
      logic [31:0] e;
      if (i == 9) continue;
      xfer(1'b0, i, '0);
      if (i == 8 || i == 20 || i == 21 || i == 23) e = pat(i);
      else e = '0; // R9 unmapped and R6 status (stopped, no done)
      chk((i == 8 || i == 20 || i == 21 || i == 23) ? "R3 rw readback" :
          (i == 16) ? "R6 status ignores write" : "R9 unmapped reads zero", rdv, e);
      chk("R2 ack with read", ackSeen, 1);
    end
    chk("R3 modeCfg", modeCfg, pat(8));
    chk("R3 hostAddr", hostAddr, {pat(21), pat(20)});
    chk("R3 localAddr", localAddr, pat(23));

    // start
    engReady = 1;
    xfer(1'b1, 9, 32'h1);
    chk("R4 start pulse", {startSeen, frstSeen, engRun}, 3'b101);
    @(negedge clk);
    chk("R4 start single cycle", engStart, 0);
    xfer(1'b0, 16, '0);
    chk("R6 status ready", rdv, 32'h100);
    xfer(1'b1, 9, 32'h1);
    chk("R4 no pulse while running", startSeen, 0);

    // completion
    pulseDone();
    xfer(1'b0, 16, '0);
    chk("R7 done set", rdv, 32'h120);
    repeat (5) @(negedge clk);
    xfer(1'b0, 16, '0);
    chk("R7 done sticky", rdv, 32'h120);
    xfer(1'b1, 16, 32'hFFFF_FFFF);
    xfer(1'b0, 16, '0);
    chk("R6 status write ignored", rdv, 32'h120);

    // same-cycle flush and done
    xfer(1'b1, 9, 32'h11, 1'b1);
    chk("R5 flush pulse", {frstSeen, startSeen}, 2'b10);
    @(negedge clk);
    chk("R5 flush single cycle", engFifoRst, 0);
    xfer(1'b0, 16, '0);
    chk("R8 flush beats done", rdv, 32'h100);
    xfer(1'b0, 9, '0);
    chk("R5 flush bit self-clears", rdv, 32'h1);

    // stop keeps flag; flag then flushed; done ignored when stopped
    pulseDone();
    xfer(1'b1, 9, 32'h0);
    chk("R4 stop", engRun, 0);
    xfer(1'b0, 16, '0);
    chk("R7 done kept after stop", rdv, 32'h020);
    xfer(1'b1, 9, 32'h10);
    pulseDone();
    xfer(1'b0, 16, '0);
    chk("R7 done ignored when stopped", rdv, 32'h0);

    // start clears an earlier flag, then poll for completion
    xfer(1'b1, 9, 32'h1);
    pulseDone();
    xfer(1'b1, 9, 32'h0);
    xfer(1'b1, 9, 32'h1);
    xfer(1'b0, 16, '0);
    chk("R7 start clears done", rdv, 32'h100);
    found = 0;
    for (int p = 0; p < 20; p++) begin
      xfer(1'b0, 16, '0);
      if (rdv[5]) begin found = 1; break; end
      if (p == 3) pulseDone();
    end
    chk("R7 poll sees completion", found, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule